// File: doc/BRIEF.md
# Two-Wire Configuration Write Slave for an Audio Control Block

This block sits on a two-wire serial bus (I2C-style signalling) and accepts configuration writes for an audio control device. It oversamples the clock and data lines with a faster system clock. It detects START and STOP conditions, assembles bytes MSB first, and acknowledges each byte by pulling the data line low during the ninth clock. A write transfer is a START, a device address byte that carries the direction flag in its LSB, a subaddress byte, one or more data bytes and a STOP. The data bytes are stored in seven 8-bit control registers, and every register drives a parallel output.

The low three subaddress bits pick the target register. Bit 4 of the subaddress chooses between two burst modes: advancing through the register map, or rewriting the same register. An active-low mute pin forces the mute output on, whatever the registers hold. The controller is one state machine. ST_IDLE waits for a START. ST_DEVADR shifts in the address byte and moves to ST_DEVACK on a match with a write flag, or to ST_SKIP otherwise. ST_DEVACK drives the acknowledge and goes to ST_SUBADR. ST_SUBADR collects the subaddress, and ST_SUBACK acknowledges it and goes to ST_DATA. ST_DATA collects a data byte, and ST_DATACK acknowledges it, commits it and returns to ST_DATA. ST_SKIP ignores the bus. A START from any state enters ST_DEVADR, and a STOP from any state enters ST_IDLE.

Top module: `audio_cfg_i2c_slave`

## Requirements
- R1: A START (data line falling while the clock line is high) begins a transfer from any state. A STOP (data line rising while the clock line is high) ends it, and bytes clocked after a STOP with no new START are neither acknowledged nor stored.
- R2: An address byte whose upper seven bits equal DEV_ADDR and whose LSB is 0 (write) is acknowledged. The subaddress byte and every data byte that follows are acknowledged as well. To acknowledge, the slave pulls the data line low for the whole ninth clock high phase.
- R3: An address byte with a different device address, or with the LSB set to 1 (read), is not acknowledged. The rest of that transfer is neither acknowledged nor stored.
- R4: Subaddress bits [2:0] select the register: 1 = mode, 2 = left gain, 3 = right gain, 4 to 7 = filter settings 0 to 3. Bits 7, 6, 5 and 3 have no effect.
- R5: With subaddress bit 4 set to 1, each data byte after the first goes to the next register code, and the code wraps from 7 to 0.
- R6: With subaddress bit 4 set to 0, every data byte of the transfer rewrites the same register.
- R7: A data byte aimed at code 0 is acknowledged and then discarded, so no register changes.
- R8: mute_o is 1 while mute_n_i is 0, or while bit 0 of the mode register is 0. It is 0 only when mute_n_i is 1 and mode bit 0 is 1.
- R9: Reset clears all seven registers to 0x00, so the block comes out of reset muted.
- R10: A data byte shows on its register output only at the rising clock edge of its acknowledge (ninth) clock. Until then the output keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = pull the open-drain data line low (acknowledge) |
| mute_n_i | input | 1 | Active-low mute request pin |
| mute_o | output | 1 | Mute output |
| mode_o | output | 8 | Mode register (code 1) |
| gain_left_o | output | 8 | Left gain register (code 2) |
| gain_right_o | output | 8 | Right gain register (code 3) |
| hpf_o | output | 32 | Filter registers for codes 4..7, with code 4 in bits [7:0] |

## Verification
The bench builds the block with its default parameters: DEV_ADDR = 0x44 and a two-stage synchronizer. A bus quarter period of eight system clocks leaves the three-cycle synchronizer latency well inside each bus phase. These values put every register code within reach of single-byte writes, of three-byte bursts that wrap through code 0, and of bursts that rewrite one register. The bench also sends wrong-address and read-flag bytes to reach the ignore state, and it checks a register output before and after the acknowledge clock of its data byte.

// File: rtl/acfg_pkg.sv
package acfg_pkg;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 3;
    localparam int NUM_SLOT = 2 ** SEL_W;
    localparam int AINC_BIT = 4;
    localparam int MUTE_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_SUBADR,
        ST_SUBACK,
        ST_DATA,
        ST_DATACK,
        ST_SKIP
    } link_state_t;
endpackage

// File: rtl/acfg_line_sync.sv
module acfg_line_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    localparam int PIPE_W = SYNC_DEPTH + 1;

    logic [1:0] raw_line;
    logic [1:0] now_line;
    logic [1:0] old_line;

    assign raw_line = {scl_i, sda_i};

    // one synchronizer chain per bus line; the extra stage keeps the previous value
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [PIPE_W-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '1;
            end else begin
                pipe_q <= {pipe_q[PIPE_W-2:0], raw_line[g]};
            end
        end
        assign now_line[g] = pipe_q[SYNC_DEPTH-1];
        assign old_line[g] = pipe_q[SYNC_DEPTH];
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = now_line[1];
    assign scl_old = old_line[1];
    assign sda_now = now_line[0];
    assign sda_old = old_line[0];

    always_comb begin
        scl_rise  = scl_now & ~scl_old;
        scl_fall  = ~scl_now & scl_old;
        start_det = scl_now & scl_old & sda_old & ~sda_now;
        stop_det  = scl_now & scl_old & ~sda_old & sda_now;
        sda_bit   = sda_now;
    end
endmodule

// File: rtl/acfg_link_fsm.sv
module acfg_link_fsm
    import acfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_bit,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_sel,
    output logic [REG_W-1:0] wr_data
);
    localparam int                CNT_W    = $clog2(REG_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W - 1);

    link_state_t      state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [REG_W-1:0] shift_q;
    logic             ack_phase_q;
    logic [SEL_W-1:0] ptr_q;
    logic             ainc_q;

    logic             byte_done;
    logic [REG_W-1:0] full_byte;
    logic             in_ack_state;
    logic             ack_done;
    logic             commit;

    assign byte_done    = scl_rise && (bit_cnt_q == LAST_BIT);
    assign full_byte    = {shift_q[REG_W-2:0], sda_bit};
    assign in_ack_state = (state_q == ST_DEVACK) || (state_q == ST_SUBACK) ||
                          (state_q == ST_DATACK);
    assign ack_done     = scl_fall && ack_phase_q;
    assign commit       = (state_q == ST_DATACK) && ack_phase_q && scl_rise;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEVADR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_DEVADR: if (byte_done)
                               state_d = (full_byte[REG_W-1:1] == DEV_ADDR && !full_byte[0])
                                         ? ST_DEVACK : ST_SKIP;
                ST_DEVACK: if (ack_done)  state_d = ST_SUBADR;
                ST_SUBADR: if (byte_done) state_d = ST_SUBACK;
                ST_SUBACK: if (ack_done)  state_d = ST_DATA;
                ST_DATA:   if (byte_done) state_d = ST_DATACK;
                ST_DATACK: if (ack_done)  state_d = ST_DATA;
                ST_SKIP:   state_d = ST_SKIP;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte assembly, acknowledge phase and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            shift_q     <= '0;
            ack_phase_q <= 1'b0;
            ptr_q       <= '0;
            ainc_q      <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt_q   <= '0;
            ack_phase_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DEVADR, ST_SUBADR, ST_DATA: begin
                    ack_phase_q <= 1'b0;
                    if (scl_rise) begin
                        shift_q   <= full_byte;
                        bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
                    end
                    if (byte_done && state_q == ST_SUBADR) begin
                        ptr_q  <= full_byte[SEL_W-1:0];
                        ainc_q <= full_byte[AINC_BIT];
                    end
                end
                ST_DEVACK, ST_SUBACK, ST_DATACK: begin
                    if (scl_fall) ack_phase_q <= ~ack_phase_q;
                    if (commit && ainc_q) ptr_q <= ptr_q + 1'b1;
                end
                default: begin
                    bit_cnt_q   <= '0;
                    ack_phase_q <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = in_ack_state && ack_phase_q;
        wr_en    = commit;
        wr_sel   = ptr_q;
        wr_data  = shift_q;
    end

    p_start_enters_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_DEVADR));

    p_stop_enters_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state_q == ST_IDLE));

    p_pull_only_in_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (state_q inside {ST_DEVACK, ST_SUBACK, ST_DATACK}));

    p_skip_is_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> (!sda_pull && !wr_en));

    p_ptr_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ainc_q && !start_det && !stop_det) |=> (ptr_q == $past(ptr_q) + 1'b1));

    p_ptr_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ainc_q) |=> $stable(ptr_q));
endmodule

// File: rtl/acfg_reg_bank.sv
module acfg_reg_bank
    import acfg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SEL_W-1:0]                  wr_sel,
    input  logic [REG_W-1:0]                  wr_data,
    output logic [(NUM_SLOT-1)*REG_W-1:0]     bank_o
);
    // slot 0 has no storage; slots 1..NUM_SLOT-1 are real registers
    for (genvar s = 1; s < NUM_SLOT; s++) begin : g_slot
        logic [REG_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && wr_sel == SEL_W'(s)) begin
                slot_q <= wr_data;
            end
        end
        assign bank_o[(s-1)*REG_W +: REG_W] = slot_q;

        p_slot_takes_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(s)) |=> (bank_o[(s-1)*REG_W +: REG_W] == $past(wr_data)));
    end

    p_code0_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> $stable(bank_o));

    p_idle_bank_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_o));
endmodule

// File: rtl/audio_cfg_i2c_slave.sv
module audio_cfg_i2c_slave
    import acfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h44,
    parameter int         SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull_o,
    input  logic        mute_n_i,
    output logic        mute_o,
    output logic [7:0]  mode_o,
    output logic [7:0]  gain_left_o,
    output logic [7:0]  gain_right_o,
    output logic [31:0] hpf_o
);
    logic             scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic             wr_en;
    logic [SEL_W-1:0] wr_sel;
    logic [REG_W-1:0] wr_data;
    logic [(NUM_SLOT-1)*REG_W-1:0] bank;

    acfg_line_sync #(.SYNC_DEPTH(SYNC_DEPTH)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    acfg_link_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .sda_pull  (sda_pull_o),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    acfg_reg_bank i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .bank_o  (bank)
    );

    always_comb begin
        mode_o       = bank[0*REG_W +: REG_W];
        gain_left_o  = bank[1*REG_W +: REG_W];
        gain_right_o = bank[2*REG_W +: REG_W];
        hpf_o        = bank[3*REG_W +: 4*REG_W];
        mute_o       = !mute_n_i || !mode_o[MUTE_BIT];
    end

    p_mode_write_unmutes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_n_i && $past(mute_n_i) && wr_en && wr_sel == 3'd1 && wr_data[MUTE_BIT])
        |=> (!mute_n_i || !mute_o));
endmodule

// File: tb/test_audio_cfg_i2c_slave.sv
module test_audio_cfg_i2c_slave;
    localparam logic [6:0] DEV = 7'h44;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic mute_n = 1'b1;
    logic sda_pull, mute_o;
    logic [7:0] mode_o, gl_o, gr_o;
    logic [31:0] hpf_o;
    logic sda_line;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    audio_cfg_i2c_slave #(.DEV_ADDR(DEV), .SYNC_DEPTH(2)) i_audio_cfg_i2c_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_pull_o   (sda_pull),
        .mute_n_i     (mute_n),
        .mute_o       (mute_o),
        .mode_o       (mode_o),
        .gain_left_o  (gl_o),
        .gain_right_o (gr_o),
        .hpf_o        (hpf_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] model [8];

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] port_reg(input int idx);
        case (idx)
            1: return mode_o;
            2: return gl_o;
            3: return gr_o;
            4: return hpf_o[7:0];
            5: return hpf_o[15:8];
            6: return hpf_o[23:16];
            7: return hpf_o[31:24];
            default: return 8'h00;
        endcase
    endfunction

    task automatic wq(input int n);
        repeat (n * Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(2);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; wq(1);
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
        end
    endtask

    task automatic ack_clk(output logic acked);
        scl_m = 1'b0; wq(1);
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        acked = ~sda_line;
        wq(1);
    endtask

    task automatic byte_ack(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        send8(b);
        ack_clk(a);
        chk(req, "acknowledge", {31'd0, a}, {31'd0, exp_ack});
    endtask

    task automatic cmp_all(input string req);
        for (int r = 1; r < 8; r++) chk(req, $sformatf("register %0d", r), {24'd0, port_reg(r)}, {24'd0, model[r]});
    endtask

    // {count[1:0], subaddress, data0, data1, data2}
    localparam int NV = 8;
    localparam logic [33:0] VEC [NV] = '{
        {2'd1, 8'h01, 8'h5A, 8'h00, 8'h00},   // R4 mode
        {2'd1, 8'hE2, 8'h11, 8'h00, 8'h00},   // R4 high don't-care bits
        {2'd1, 8'h0B, 8'h22, 8'h00, 8'h00},   // R4 bit 3 don't-care
        {2'd2, 8'h14, 8'h33, 8'h44, 8'h00},   // R5 advance
        {2'd2, 8'h06, 8'h55, 8'h66, 8'h00},   // R6 same register
        {2'd3, 8'h17, 8'h77, 8'h88, 8'h03},   // R5 wrap through code 0 (R7)
        {2'd1, 8'h00, 8'h99, 8'h00, 8'h00},   // R7 code 0 discarded
        {2'd1, 8'h11, 8'h01, 8'h00, 8'h00}    // mode bit 0 set
    };

    initial begin
        logic [2:0] p;
        logic [7:0] d;
        logic a;
        for (int r = 0; r < 8; r++) model[r] = 8'h00;
        repeat (10) @(posedge clk);
        #1 rst_n = 1'b1;
        wq(2);

        // R9 reset state
        cmp_all("R9");
        chk("R9", "muted after reset", {31'd0, mute_o}, 32'd1);

        // table walk
        for (int v = 0; v < NV; v++) begin
            bus_start();
            byte_ack({DEV, 1'b0}, 1'b1, "R2");
            byte_ack(VEC[v][31:24], 1'b1, "R2");
            p = VEC[v][26:24];
            for (int k = 0; k < int'(VEC[v][33:32]); k++) begin
                d = VEC[v][23 - 8*k -: 8];
                byte_ack(d, 1'b1, "R2");
                if (p != 3'd0) model[p] = d;
                if (VEC[v][28]) p = p + 3'd1;
            end
            bus_stop();
            cmp_all($sformatf("R4/R5/R6/R7 vector %0d", v));
        end

        // R8 mute behaviour
        chk("R8", "unmuted with pin high and mode bit0", {31'd0, mute_o}, 32'd0);
        mute_n = 1'b0; wq(1);
        chk("R8", "pin forces mute", {31'd0, mute_o}, 32'd1);
        mute_n = 1'b1; wq(1);

        // R3 wrong device address
        bus_start();
        byte_ack({DEV ^ 7'h01, 1'b0}, 1'b0, "R3");
        byte_ack(8'h01, 1'b0, "R3");
        byte_ack(8'hFE, 1'b0, "R3");
        bus_stop();
        cmp_all("R3 wrong address");

        // R3 read flag
        bus_start();
        byte_ack({DEV, 1'b1}, 1'b0, "R3");
        byte_ack(8'h02, 1'b0, "R3");
        byte_ack(8'hEE, 1'b0, "R3");
        bus_stop();
        cmp_all("R3 read flag");

        // R1 bytes after STOP without START are ignored
        bus_start();
        byte_ack({DEV, 1'b0}, 1'b1, "R1");
        byte_ack(8'h02, 1'b1, "R1");
        byte_ack(8'h5C, 1'b1, "R1");
        bus_stop();
        model[2] = 8'h5C;
        byte_ack(8'hAB, 1'b0, "R1");
        byte_ack(8'hCD, 1'b0, "R1");
        bus_stop();
        cmp_all("R1");

        // R10 value appears at acknowledge clock
        bus_start();
        byte_ack({DEV, 1'b0}, 1'b1, "R10");
        byte_ack(8'h05, 1'b1, "R10");
        send8(8'hC3);
        chk("R10", "before acknowledge clock", {24'd0, port_reg(5)}, {24'd0, model[5]});
        ack_clk(a);
        chk("R10", "after acknowledge clock", {24'd0, port_reg(5)}, 32'h0000_00C3);
        chk("R10", "acknowledge", {31'd0, a}, 32'd1);
        bus_stop();
        model[5] = 8'hC3;
        cmp_all("R10");

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule